// File: doc/BRIEF.md
# Wake Source Flag Register

This block records which event brought the chip out of a low-power period. It keeps one sticky flag for each of twelve sources, and software reads these flags after it resumes. Six of the sources are wake sources. These are a timer-expiry strobe, a push-button pin, a serial receive pin, two general-purpose pins, and an optical receive path. The other six are reset-class sources: a reset pin, an emulator reset, a watchdog overflow, a cold start, a software reset bit and a supply fault.

Each asynchronous pin passes through a synchronizer. It is then detected as a high level, a rising edge or either edge, depending on the source. The reset-class flags clear each other through a fixed matrix, so in most cases only the latest reset cause stays visible. The controlling wake signal clears every flag when it falls, which marks entry into a low-power mode. A combined wake request is raised while the chip is in low power and any wake-class flag is set.

Top module: `wake_flag_reg`

## Requirements
- R1: A falling edge of `wake_i` (high in one cycle, low in the next) clears all twelve flags at the following clock edge. This clear takes priority over every set event in that cycle.
- R2: A one-cycle `tmr_expire_i` strobe sets `flags_o[0]` at the next clock edge.
- R3: After a two-stage synchronizer, `flags_o[1]` sets on a high level of the push-button pin and `flags_o[2]` sets on either edge of the serial receive pin. `flags_o[3]` sets on a rising edge of its general-purpose pin only, and `flags_o[4]` sets on a high level of its general-purpose pin.
- R4: When `opt_rx_dis_i` is 1, `flags_o[5]` sets on a high level of `opt_alt_pin_i` and edges on `opt_rx_pin_i` are ignored. When it is 0, the flag sets on either edge of `opt_rx_pin_i` and `opt_alt_pin_i` is ignored.
- R5: `flags_o[7]` sets when the emulator reset pin and the emulator enable pin are both high, on the rising edge of that combined condition. It never sets while the enable pin is low.
- R6: `flags_o[6]` sets on a rising edge of the synchronized reset pin.
- R7: One-cycle strobes set their flags at the next clock edge: watchdog overflow sets bit 8, cold start sets bit 9, the software reset bit sets bit 10 and supply fault sets bit 11.
- R8: When a reset-class flag newly sets, it clears other flags as follows. Bit 6 is cleared by a new bit 8, 9, 10 or 11. Bit 10 is cleared by a new bit 6, 8, 9 or 11. Bit 7 is cleared by a new bit 6, 8, 9 or 10. Bit 8 is cleared by a new bit 6, 9, 10 or 11. Bit 9 is cleared by a new bit 6, 8, 10 or 11. Bit 11 is cleared only by R1.
- R9: Suppose a flag's own set event occurs in the same cycle as one of its clearing events. Then the flag ends up set. A set event for a flag that is already set clears nothing.
- R10: Apart from R1 and R8, a set flag holds its value.
- R11: `wake_req_o` is high only when `lowpwr_i` is high and at least one of `flags_o[5:0]` is set. Bits 6 to 11 never raise it.
- R12: While `rst_n` is low, all flags and `wake_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_i | input | 1 | Wake signal; its falling edge clears all flags |
| lowpwr_i | input | 1 | High while the chip is in a low-power mode |
| opt_rx_dis_i | input | 1 | Selects the optical source: 1 = alternate pin level, 0 = receive pin either edge |
| tmr_expire_i | input | 1 | Timer expiry strobe |
| wdog_ovf_i | input | 1 | Watchdog overflow strobe |
| cold_start_i | input | 1 | Cold start strobe |
| sw_rst_i | input | 1 | Software reset bit strobe |
| supply_fault_i | input | 1 | Supply fault strobe |
| btn_pin_i | input | 1 | Push-button pin (async) |
| rx_pin_i | input | 1 | Serial receive pin (async) |
| gp_rise_pin_i | input | 1 | General-purpose pin, rising edge (async) |
| gp_level_pin_i | input | 1 | General-purpose pin, high level (async) |
| opt_alt_pin_i | input | 1 | Alternate optical pin (async) |
| opt_rx_pin_i | input | 1 | Optical receive pin (async) |
| rst_pin_i | input | 1 | Reset pin (async) |
| emu_rst_pin_i | input | 1 | Emulator reset pin (async) |
| emu_en_pin_i | input | 1 | Emulator enable pin (async) |
| flags_o | output | 12 | Sticky wake-source flags |
| wake_req_o | output | 1 | Combined wake request |

## Verification
The assertions assume that the strobe inputs and `wake_i` are synchronous to `clk`. They also assume that the first cycle after reset release does not count as a wake falling edge. The cross-clear checks rely on the reset-class flags being set only through their own events. The stimulus changes every input on the falling clock edge. It pulses each strobe for exactly one cycle and keeps each pin stable for longer than the synchronizer depth. Level-type pins are returned low before a wake fall clears the flags, so no flag is set again behind the check.

// File: rtl/wfr_pkg.sv
package wfr_pkg;

    localparam int NFLAG = 12;
    localparam int NPIN  = 9;

    // flag positions
    localparam int F_TMR   = 0;
    localparam int F_BTN   = 1;
    localparam int F_RX    = 2;
    localparam int F_GPR   = 3;
    localparam int F_GPL   = 4;
    localparam int F_OPT   = 5;
    localparam int F_RPIN  = 6;
    localparam int F_EMU   = 7;
    localparam int F_WDOG  = 8;
    localparam int F_COLD  = 9;
    localparam int F_SWRST = 10;
    localparam int F_SFLT  = 11;

    localparam int NWAKE = 6;

    // synchronized pin positions
    localparam int P_BTN  = 0;
    localparam int P_RX   = 1;
    localparam int P_GPR  = 2;
    localparam int P_GPL  = 3;
    localparam int P_OALT = 4;
    localparam int P_ORX  = 5;
    localparam int P_RPIN = 6;
    localparam int P_ERST = 7;
    localparam int P_EEN  = 8;

    typedef enum logic [1:0] {
        DET_LEVEL = 2'd0,
        DET_RISE  = 2'd1,
        DET_BOTH  = 2'd2
    } det_mode_e;

    typedef struct packed {
        logic [NFLAG-1:0] flags;
        logic [NPIN-1:0]  pin_prev;
        logic             wake_prev;
    } wfr_state_t;

    // Which flags, on newly setting, clear flag idx.
    function automatic logic [NFLAG-1:0] cleared_by(input int idx);
        logic [NFLAG-1:0] m;
        m = '0;
        case (idx)
            F_RPIN:  begin m[F_COLD] = 1'b1; m[F_SWRST] = 1'b1; m[F_WDOG] = 1'b1; m[F_SFLT] = 1'b1; end
            F_SWRST: begin m[F_COLD] = 1'b1; m[F_WDOG] = 1'b1; m[F_SFLT] = 1'b1; m[F_RPIN] = 1'b1; end
            F_EMU:   begin m[F_COLD] = 1'b1; m[F_RPIN] = 1'b1; m[F_WDOG] = 1'b1; m[F_SWRST] = 1'b1; end
            F_WDOG:  begin m[F_COLD] = 1'b1; m[F_SWRST] = 1'b1; m[F_SFLT] = 1'b1; m[F_RPIN] = 1'b1; end
            F_COLD:  begin m[F_SWRST] = 1'b1; m[F_WDOG] = 1'b1; m[F_SFLT] = 1'b1; m[F_RPIN] = 1'b1; end
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wfr_sync.sv
module wfr_sync #(
    parameter int WIDTH  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/wfr_detect.sv
module wfr_detect
    import wfr_pkg::*;
#(
    parameter det_mode_e MODE = DET_LEVEL
) (
    input  logic cur_i,
    input  logic prev_i,
    output logic hit_o
);
    always_comb begin
        unique case (MODE)
            DET_LEVEL: hit_o = cur_i;
            DET_RISE:  hit_o = cur_i & ~prev_i;
            DET_BOTH:  hit_o = cur_i ^ prev_i;
            default:   hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/wfr_xclr.sv
module wfr_xclr
    import wfr_pkg::*;
(
    input  logic [NFLAG-1:0] rise_i,
    output logic [NFLAG-1:0] clr_o
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_row
        localparam logic [NFLAG-1:0] ROW = cleared_by(i);
        assign clr_o[i] = |(rise_i & ROW);
    end
endmodule

// File: rtl/wake_flag_reg.sv
module wake_flag_reg
    import wfr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake_i,
    input  logic             lowpwr_i,
    input  logic             opt_rx_dis_i,
    input  logic             tmr_expire_i,
    input  logic             wdog_ovf_i,
    input  logic             cold_start_i,
    input  logic             sw_rst_i,
    input  logic             supply_fault_i,
    input  logic             btn_pin_i,
    input  logic             rx_pin_i,
    input  logic             gp_rise_pin_i,
    input  logic             gp_level_pin_i,
    input  logic             opt_alt_pin_i,
    input  logic             opt_rx_pin_i,
    input  logic             rst_pin_i,
    input  logic             emu_rst_pin_i,
    input  logic             emu_en_pin_i,
    output logic [11:0]      flags_o,
    output logic             wake_req_o
);
    localparam logic [NFLAG-1:0] WAKE_MASK = NFLAG'((1 << NWAKE) - 1);

    wfr_state_t st_d, st_q;

    logic [NPIN-1:0]  pin_raw, pin_s;
    logic [NFLAG-1:0] set_ev, rise, clr;
    logic             opt_lvl_hit, opt_edge_hit;
    logic             emu_cur, emu_prev;

    assign pin_raw[P_BTN]  = btn_pin_i;
    assign pin_raw[P_RX]   = rx_pin_i;
    assign pin_raw[P_GPR]  = gp_rise_pin_i;
    assign pin_raw[P_GPL]  = gp_level_pin_i;
    assign pin_raw[P_OALT] = opt_alt_pin_i;
    assign pin_raw[P_ORX]  = opt_rx_pin_i;
    assign pin_raw[P_RPIN] = rst_pin_i;
    assign pin_raw[P_ERST] = emu_rst_pin_i;
    assign pin_raw[P_EEN]  = emu_en_pin_i;

    wfr_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_raw),
        .sync_o  (pin_s)
    );

    // pin detectors: flag index, pin index and detection mode per source
    localparam int        NDET = 4;
    localparam int        DET_FLAG [NDET] = '{F_BTN, F_RX, F_GPR, F_GPL};
    localparam int        DET_PIN  [NDET] = '{P_BTN, P_RX, P_GPR, P_GPL};
    localparam det_mode_e DET_MODE [NDET] = '{DET_LEVEL, DET_BOTH, DET_RISE, DET_LEVEL};

    for (genvar k = 0; k < NDET; k++) begin : g_det
        wfr_detect #(.MODE(DET_MODE[k])) u_det (
            .cur_i  (pin_s[DET_PIN[k]]),
            .prev_i (st_q.pin_prev[DET_PIN[k]]),
            .hit_o  (set_ev[DET_FLAG[k]])
        );
    end

    wfr_detect #(.MODE(DET_LEVEL)) u_det_oalt (
        .cur_i  (pin_s[P_OALT]),
        .prev_i (st_q.pin_prev[P_OALT]),
        .hit_o  (opt_lvl_hit)
    );

    wfr_detect #(.MODE(DET_BOTH)) u_det_orx (
        .cur_i  (pin_s[P_ORX]),
        .prev_i (st_q.pin_prev[P_ORX]),
        .hit_o  (opt_edge_hit)
    );

    wfr_detect #(.MODE(DET_RISE)) u_det_rpin (
        .cur_i  (pin_s[P_RPIN]),
        .prev_i (st_q.pin_prev[P_RPIN]),
        .hit_o  (set_ev[F_RPIN])
    );

    assign emu_cur  = pin_s[P_ERST] & pin_s[P_EEN];
    assign emu_prev = st_q.pin_prev[P_ERST] & st_q.pin_prev[P_EEN];

    wfr_detect #(.MODE(DET_RISE)) u_det_emu (
        .cur_i  (emu_cur),
        .prev_i (emu_prev),
        .hit_o  (set_ev[F_EMU])
    );

    assign set_ev[F_OPT]   = opt_rx_dis_i ? opt_lvl_hit : opt_edge_hit;
    assign set_ev[F_TMR]   = tmr_expire_i;
    assign set_ev[F_WDOG]  = wdog_ovf_i;
    assign set_ev[F_COLD]  = cold_start_i;
    assign set_ev[F_SWRST] = sw_rst_i;
    assign set_ev[F_SFLT]  = supply_fault_i;

    // only a flag that is not yet set can cross-clear others
    assign rise = set_ev & ~st_q.flags;

    wfr_xclr u_xclr (
        .rise_i (rise),
        .clr_o  (clr)
    );

    always_comb begin
        st_d           = st_q;
        st_d.pin_prev  = pin_s;
        st_d.wake_prev = wake_i;
        if (st_q.wake_prev && !wake_i) begin
            st_d.flags = '0;
        end else begin
            st_d.flags = set_ev | (st_q.flags & ~clr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o    = st_q.flags;
    assign wake_req_o = lowpwr_i & (|(st_q.flags & WAKE_MASK));
endmodule

// File: rtl/wfr_checker.sv
module wfr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wake_i,
    input logic        lowpwr_i,
    input logic        supply_fault_i,
    input logic [11:0] flags_o,
    input logic        wake_req_o
);
    // R1: wake falling edge empties the flag vector
    a_r1_wake_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(wake_i) |=> flags_o == 12'h000);

    // R11: request only in low power with a wake-class flag
    a_r11_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> lowpwr_i && (|flags_o[5:0]));

    // R7: supply fault sets its flag unless a wake fall clears
    a_r7_sflt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        supply_fault_i && !$fell(wake_i) |=> flags_o[11]);

    // R8: a newly set cold-start flag leaves the reset-pin flag clear unless that one also rose
    a_r8_cold_clears_rpin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[9]) && !$rose(flags_o[6]) |-> !flags_o[6]);

    // R8: a newly set watchdog flag clears the software-reset flag
    a_r8_wdog_clears_swrst: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[8]) && !$rose(flags_o[10]) |-> !flags_o[10]);

    // R10: wake-class flags only drop after a wake fall
    a_r10_wake_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flags_o[5:0]) & ~flags_o[5:0])) |-> $past($fell(wake_i)));
endmodule

bind wake_flag_reg wfr_checker u_wfr_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .wake_i         (wake_i),
    .lowpwr_i       (lowpwr_i),
    .supply_fault_i (supply_fault_i),
    .flags_o        (flags_o),
    .wake_req_o     (wake_req_o)
);

// File: tb/wake_flag_reg_test.sv
`timescale 1ns/1ps
module wake_flag_reg_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wake = 1'b0, lowpwr = 1'b0, opt_dis = 1'b0;
    logic tmr = 1'b0, wdog = 1'b0, cold = 1'b0, swrst = 1'b0, sflt = 1'b0;
    logic btn = 1'b0, rx = 1'b0, gpr = 1'b0, gpl = 1'b0, oalt = 1'b0, orx = 1'b0;
    logic rpin = 1'b0, erst = 1'b0, een = 1'b0;
    logic [11:0] flags;
    logic        req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wake_flag_reg uut (
        .clk(clk), .rst_n(rst_n), .wake_i(wake), .lowpwr_i(lowpwr),
        .opt_rx_dis_i(opt_dis), .tmr_expire_i(tmr), .wdog_ovf_i(wdog),
        .cold_start_i(cold), .sw_rst_i(swrst), .supply_fault_i(sflt),
        .btn_pin_i(btn), .rx_pin_i(rx), .gp_rise_pin_i(gpr), .gp_level_pin_i(gpl),
        .opt_alt_pin_i(oalt), .opt_rx_pin_i(orx), .rst_pin_i(rpin),
        .emu_rst_pin_i(erst), .emu_en_pin_i(een),
        .flags_o(flags), .wake_req_o(req)
    );

    // strobe bits {sfault, swrst, cold, wdog, tmr} and expected flags after the pulse
    localparam logic [16:0] VEC [0:9] = '{
        {5'b00001, 12'h001},   // R2 timer
        {5'b00010, 12'h101},   // R7 watchdog
        {5'b00100, 12'h201},   // R8 cold clears watchdog
        {5'b01000, 12'h401},   // R8 swrst clears cold
        {5'b00010, 12'h101},   // R8 watchdog clears swrst
        {5'b10000, 12'h801},   // R8 supply fault clears watchdog
        {5'b00100, 12'hA01},   // R8 cold leaves supply fault
        {5'b10000, 12'hA01},   // R9 re-set of supply fault clears nothing
        {5'b00110, 12'hB01},   // R9 cold set event beats watchdog clear
        {5'b01000, 12'hC01}    // R8 swrst clears cold and watchdog
    };

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [4:0] s);
        @(negedge clk);
        {sflt, swrst, cold, wdog, tmr} = s;
        @(negedge clk);
        {sflt, swrst, cold, wdog, tmr} = 5'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 flags in reset", flags, 12'h000);
        check("R12 req in reset", {11'b0, req}, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table walk
        foreach (VEC[i]) begin
            pulse(VEC[i][16:12]);
            check($sformatf("R8 vector %0d", i), flags, VEC[i][11:0]);
        end

        // R1: wake fall clears, and beats a same-cycle strobe
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0; tmr = 1'b1; cold = 1'b1;
        @(negedge clk); tmr = 1'b0; cold = 1'b0;
        check("R1 wake fall clears", flags, 12'h000);

        // R11: request gating
        pulse(5'b00010);
        lowpwr = 1'b1; #1;
        check("R11 reset-class only no req", {11'b0, req}, 12'h000);
        pulse(5'b00001);
        #1 check("R11 req in low power", {11'b0, req}, 12'h001);
        lowpwr = 1'b0; #1;
        check("R11 req off outside low power", {11'b0, req}, 12'h000);
        check("R10 flags hold", flags, 12'h101);
        clear_flags();

        // R3: pin sources
        @(negedge clk); btn = 1'b1; settle();
        check("R3 button level", flags, 12'h002);
        btn = 1'b0; settle(); clear_flags();
        @(negedge clk); rx = 1'b1; settle();
        check("R3 rx rising", flags, 12'h004);
        clear_flags(); rx = 1'b0; settle();
        check("R3 rx falling", flags, 12'h004);
        clear_flags();
        @(negedge clk); gpr = 1'b1; settle();
        check("R3 gp rise", flags, 12'h008);
        clear_flags(); gpr = 1'b0; settle();
        check("R3 gp fall ignored", flags, 12'h000);
        gpl = 1'b1; settle();
        check("R3 gp level", flags, 12'h010);
        gpl = 1'b0; settle(); clear_flags();

        // R4: optical source selection
        opt_dis = 1'b1; orx = 1'b1; settle();
        check("R4 rx edge ignored when disabled", flags, 12'h000);
        oalt = 1'b1; settle();
        check("R4 alt level", flags, 12'h020);
        oalt = 1'b0; settle(); clear_flags();
        opt_dis = 1'b0; oalt = 1'b1; settle();
        check("R4 alt ignored when enabled", flags, 12'h000);
        orx = 1'b0; settle();
        check("R4 rx edge", flags, 12'h020);
        oalt = 1'b0; settle(); clear_flags();

        // R5: emulator reset needs enable
        erst = 1'b1; settle();
        check("R5 no set without enable", flags, 12'h000);
        een = 1'b1; settle();
        check("R5 set with enable", flags, 12'h080);
        erst = 1'b0; een = 1'b0; settle(); clear_flags();

        // R6 and R8: reset pin sets and clears cold start
        pulse(5'b00100);
        check("R7 cold sets", flags, 12'h200);
        rpin = 1'b1; settle();
        check("R6 reset pin sets, clears cold (R8)", flags, 12'h040);
        pulse(5'b10000);
        check("R8 supply fault clears reset pin", flags, 12'h800);
        rpin = 1'b0; settle();

        finish_run();
    end
endmodule